// File: doc/BRIEF.md
# Tagged Audio Link Frame Controller

This block is the controller end of a five-wire audio link whose bit clock belongs to the codec. It watches the incoming bit clock, builds a fixed frame of 256 bit times split into 13 slots, and sends that frame out on the playback line. While it does so it takes in the matching frame from the capture line. It also drives the marker that tells the codec where each frame starts, and holds the codec in reset until the link is allowed to run. One frame at 12.288 MHz lasts about 21 µs, so the frame rate is about 48 kHz.

Slot 0 is a 16-bit tag slot and slots 1 to 12 carry 20 bits each. On the parallel side the block takes one tag word and twelve slot words for the outbound frame. It presents the same layout for the last complete inbound frame, and raises a single-cycle strobe each time an inbound frame is finished. The bit clock is oversampled in the system clock domain. The controller launches bits on its rising edges and samples on its falling edges.

Top module: `alink_frame_ctrl`

## Requirements
- R1: `codec_rst_n_o` is 0 while `rst` is 1 and for exactly `RST_HOLD` clock cycles after `rst` falls, then rises to 1. It is 0 in the cycle after any cycle with `rst` at 1.
- R2: While `rst` is 1, and while no frame has started, `sync_o`, `sdout_o` and `frame_done_o` are 0. A stopped bit clock never starts a frame.
- R3: Once `codec_rst_n_o` is 1, the block counts rising bit-clock edges. The rising edge numbered `ARM_EDGES`+1 in that count launches bit 0 of the first frame.
- R4: A frame is 256 bit times. `sync_o` is 1 for frame bits 0 to 15 and 0 for bits 16 to 255, and every rising bit-clock edge after the start moves to the next bit.
- R5: Frame bits 0 to 15 carry `tx_tag_i` and bits 16 to 255 carry slots 1 to 12. Slot k comes from `tx_slot_i[(k-1)*20 +: 20]`. Each slot goes out MSB first, and each bit is launched on a rising bit-clock edge.
- R6: `sdin_i` is sampled on each falling bit-clock edge using the same slot layout, MSB first. Frame bits 0 to 15 go to `rx_tag_o` and slot k goes to `rx_slot_o[(k-1)*20 +: 20]`.
- R7: `frame_done_o` is a one-cycle pulse, given once per frame after frame bit 255 has been sampled. The inbound outputs change only in that cycle and otherwise hold their value.
- R8: The outbound words are taken from the inputs when the first frame starts and again at each frame end. Changing `tx_tag_i` or `tx_slot_i` in the middle of a frame has no effect on the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Bit clock driven by the codec |
| sdin_i | input | 1 | Capture serial data from the codec |
| tx_tag_i | input | 16 | Outbound tag slot word |
| tx_slot_i | input | 240 | Outbound slots 1 to 12, 20 bits each |
| sync_o | output | 1 | Frame marker toward the codec |
| sdout_o | output | 1 | Playback serial data toward the codec |
| codec_rst_n_o | output | 1 | Active-low reset toward the codec |
| rx_tag_o | output | 16 | Inbound tag slot of the last complete frame |
| rx_slot_o | output | 240 | Inbound slots 1 to 12 of the last complete frame |
| frame_done_o | output | 1 | One-cycle strobe when an inbound frame completes |

## Verification
Three actions land on the same falling bit-clock edge at the end of a frame: the last capture bit is sampled, the inbound frame is published with its strobe, and the outbound words are reloaded. The bench provokes this edge by changing the outbound inputs at frame bit 100 of every frame. A reference model then predicts every bit of each frame. It checks that the rest of the current frame still carries the old words and that the next frame opens with the new ones. At the first bit of the following frame it also checks that the published inbound slot 12 includes its final bit.

// File: rtl/alink_pkg.sv
package alink_pkg;

    localparam int SLOTS      = 13;
    localparam int TAG_W      = 16;
    localparam int DATA_W     = 20;
    localparam int FRAME_BITS = TAG_W + (SLOTS - 1) * DATA_W;
    localparam int DATA_VEC_W = (SLOTS - 1) * DATA_W;
    localparam int SLOT_IW    = $clog2(SLOTS);
    localparam int BIT_IW     = $clog2(DATA_W);

    typedef logic [SLOT_IW-1:0] slot_idx_t;
    typedef logic [BIT_IW-1:0]  bit_idx_t;
    typedef logic [DATA_W-1:0]  slot_word_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } bclk_ev_t;

    typedef struct packed {
        slot_idx_t slot;
        bit_idx_t  bitn;
    } slot_pos_t;

    typedef struct packed {
        logic      running;
        logic      launch;
        logic      capture;
        slot_pos_t pos;
    } link_step_t;

    typedef enum logic [1:0] {
        SQ_HOLD = 2'd0,
        SQ_ARM  = 2'd1,
        SQ_RUN  = 2'd2
    } seq_state_e;

    function automatic bit_idx_t slot_last_bit(slot_idx_t s);
        return (s == '0) ? bit_idx_t'(TAG_W - 1) : bit_idx_t'(DATA_W - 1);
    endfunction

    function automatic logic is_frame_last(slot_pos_t p);
        return (p.slot == slot_idx_t'(SLOTS - 1)) && (p.bitn == slot_last_bit(p.slot));
    endfunction

    function automatic slot_pos_t next_pos(slot_pos_t p);
        slot_pos_t n;
        n = p;
        if (p.bitn == slot_last_bit(p.slot)) begin
            n.bitn = '0;
            n.slot = (p.slot == slot_idx_t'(SLOTS - 1)) ? '0 : p.slot + slot_idx_t'(1);
        end else begin
            n.bitn = p.bitn + bit_idx_t'(1);
        end
        return n;
    endfunction

    function automatic bit_idx_t msb_first_index(slot_pos_t p);
        return slot_last_bit(p.slot) - p.bitn;
    endfunction

endpackage

// File: rtl/alink_bclk_edge.sv
module alink_bclk_edge #(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bclk_i,
    output alink_pkg::bclk_ev_t ev_o
);
    // STAGES synchroniser flops plus one history flop
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], bclk_i};
        end
    end

    assign ev_o.rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign ev_o.fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/alink_sequencer.sv
module alink_sequencer
    import alink_pkg::*;
#(
    parameter int RST_HOLD  = 16,
    parameter int ARM_EDGES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  bclk_ev_t   ev_i,
    output logic       codec_rst_n_o,
    output link_step_t step_o
);
    localparam int HOLD_W = (RST_HOLD < 2) ? 1 : $clog2(RST_HOLD + 1);
    localparam int ARM_W  = (ARM_EDGES < 1) ? 1 : $clog2(ARM_EDGES + 1);

    seq_state_e       state_q;
    logic [HOLD_W-1:0] hold_cnt_q;
    logic [ARM_W-1:0]  arm_cnt_q;
    slot_pos_t        pos_q;
    logic             launch_q;
    logic             capture_q;
    logic             codec_up_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_HOLD;
            hold_cnt_q <= '0;
            arm_cnt_q  <= '0;
            pos_q      <= '0;
            launch_q   <= 1'b0;
            capture_q  <= 1'b0;
            codec_up_q <= 1'b0;
        end else begin
            launch_q  <= 1'b0;
            capture_q <= 1'b0;
            case (state_q)
                SQ_HOLD: begin
                    if (hold_cnt_q == HOLD_W'(RST_HOLD - 1)) begin
                        state_q    <= SQ_ARM;
                        codec_up_q <= 1'b1;
                    end else begin
                        hold_cnt_q <= hold_cnt_q + HOLD_W'(1);
                    end
                end
                SQ_ARM: begin
                    if (ev_i.rise) begin
                        if (arm_cnt_q == ARM_W'(ARM_EDGES)) begin
                            state_q  <= SQ_RUN;
                            pos_q    <= '0;
                            launch_q <= 1'b1;
                        end else begin
                            arm_cnt_q <= arm_cnt_q + ARM_W'(1);
                        end
                    end
                end
                SQ_RUN: begin
                    if (ev_i.rise) begin
                        pos_q    <= next_pos(pos_q);
                        launch_q <= 1'b1;
                    end
                    if (ev_i.fall) begin
                        capture_q <= 1'b1;
                    end
                end
                default: state_q <= SQ_HOLD;
            endcase
        end
    end

    assign codec_rst_n_o   = codec_up_q;
    assign step_o.running  = (state_q == SQ_RUN);
    assign step_o.launch   = launch_q;
    assign step_o.capture  = capture_q;
    assign step_o.pos      = pos_q;
endmodule

// File: rtl/alink_tx_ser.sv
module alink_tx_ser
    import alink_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  link_step_t            step_i,
    input  logic [TAG_W-1:0]      tx_tag_i,
    input  logic [DATA_VEC_W-1:0] tx_slot_i,
    output logic                  sync_o,
    output logic                  sdout_o
);
    slot_word_t in_w     [SLOTS];
    slot_word_t shadow_q [SLOTS];
    logic       reload;
    logic       sync_q;
    logic       sdout_q;

    assign in_w[0] = {{(DATA_W - TAG_W){1'b0}}, tx_tag_i};
    for (genvar k = 1; k < SLOTS; k++) begin : g_in
        assign in_w[k] = tx_slot_i[(k-1)*DATA_W +: DATA_W];
    end

    // idle: track inputs; running: freeze until the frame-end capture
    assign reload = !step_i.running || (step_i.capture && is_frame_last(step_i.pos));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SLOTS; k++) shadow_q[k] <= '0;
            sync_q  <= 1'b0;
            sdout_q <= 1'b0;
        end else begin
            if (reload) begin
                for (int k = 0; k < SLOTS; k++) shadow_q[k] <= in_w[k];
            end
            if (!step_i.running) begin
                sync_q  <= 1'b0;
                sdout_q <= 1'b0;
            end else if (step_i.launch) begin
                sync_q  <= (step_i.pos.slot == '0);
                sdout_q <= shadow_q[step_i.pos.slot][msb_first_index(step_i.pos)];
            end
        end
    end

    assign sync_o  = sync_q;
    assign sdout_o = sdout_q;
endmodule

// File: rtl/alink_rx_des.sv
module alink_rx_des
    import alink_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  link_step_t            step_i,
    input  logic                  sdin_i,
    output logic [TAG_W-1:0]      rx_tag_o,
    output logic [DATA_VEC_W-1:0] rx_slot_o,
    output logic                  done_o
);
    slot_word_t shift_q;
    slot_word_t word_in;
    slot_word_t hold_q [SLOTS];
    slot_word_t pub_q  [SLOTS];
    logic       done_q;

    assign word_in = {shift_q[DATA_W-2:0], sdin_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            done_q  <= 1'b0;
            for (int k = 0; k < SLOTS; k++) begin
                hold_q[k] <= '0;
                pub_q[k]  <= '0;
            end
        end else begin
            done_q <= 1'b0;
            if (step_i.running && step_i.capture) begin
                shift_q <= word_in;
                if (step_i.pos.bitn == slot_last_bit(step_i.pos.slot)) begin
                    hold_q[step_i.pos.slot] <= word_in;
                end
                if (is_frame_last(step_i.pos)) begin
                    for (int k = 0; k < SLOTS; k++) begin
                        pub_q[k] <= (k == SLOTS - 1) ? word_in : hold_q[k];
                    end
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign rx_tag_o = pub_q[0][TAG_W-1:0];
    for (genvar k = 1; k < SLOTS; k++) begin : g_out
        assign rx_slot_o[(k-1)*DATA_W +: DATA_W] = pub_q[k];
    end
    assign done_o = done_q;
endmodule

// File: rtl/alink_frame_ctrl.sv
module alink_frame_ctrl
    import alink_pkg::*;
#(
    parameter int RST_HOLD    = 16,
    parameter int ARM_EDGES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bclk_i,
    input  logic                  sdin_i,
    input  logic [TAG_W-1:0]      tx_tag_i,
    input  logic [DATA_VEC_W-1:0] tx_slot_i,
    output logic                  sync_o,
    output logic                  sdout_o,
    output logic                  codec_rst_n_o,
    output logic [TAG_W-1:0]      rx_tag_o,
    output logic [DATA_VEC_W-1:0] rx_slot_o,
    output logic                  frame_done_o
);
    bclk_ev_t   bclk_ev;
    link_step_t step;

    alink_bclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .bclk_i (bclk_i),
        .ev_o   (bclk_ev)
    );

    alink_sequencer #(.RST_HOLD(RST_HOLD), .ARM_EDGES(ARM_EDGES)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .ev_i          (bclk_ev),
        .codec_rst_n_o (codec_rst_n_o),
        .step_o        (step)
    );

    alink_tx_ser u_tx (
        .clk       (clk),
        .rst       (rst),
        .step_i    (step),
        .tx_tag_i  (tx_tag_i),
        .tx_slot_i (tx_slot_i),
        .sync_o    (sync_o),
        .sdout_o   (sdout_o)
    );

    alink_rx_des u_rx (
        .clk       (clk),
        .rst       (rst),
        .step_i    (step),
        .sdin_i    (sdin_i),
        .rx_tag_o  (rx_tag_o),
        .rx_slot_o (rx_slot_o),
        .done_o    (frame_done_o)
    );
endmodule

// File: rtl/alink_frame_ctrl_chk.sv
module alink_frame_ctrl_chk
    import alink_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  codec_rst_n_o,
    input logic                  sync_o,
    input logic                  sdout_o,
    input logic                  frame_done_o,
    input logic [TAG_W-1:0]      rx_tag_o,
    input logic [DATA_VEC_W-1:0] rx_slot_o
);
    AST_CODEC_HELD_IN_RST: assert property (@(posedge clk)
        rst |=> !codec_rst_n_o); // R1

    AST_LINE_QUIET_IN_RST: assert property (@(posedge clk)
        rst |=> (!sync_o && !sdout_o && !frame_done_o)); // R2

    AST_MARKER_NEEDS_CODEC: assert property (@(posedge clk) disable iff (rst)
        sync_o |-> codec_rst_n_o); // R3

    AST_DONE_OUTSIDE_MARKER: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> !sync_o); // R4

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |=> !frame_done_o); // R7

    AST_RX_HELD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !frame_done_o |-> ($stable(rx_tag_o) && $stable(rx_slot_o))); // R7
endmodule

bind alink_frame_ctrl alink_frame_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .codec_rst_n_o (codec_rst_n_o),
    .sync_o        (sync_o),
    .sdout_o       (sdout_o),
    .frame_done_o  (frame_done_o),
    .rx_tag_o      (rx_tag_o),
    .rx_slot_o     (rx_slot_o)
);

// File: tb/test_alink_frame_ctrl.sv
module test_alink_frame_ctrl;
    import alink_pkg::*;

    localparam int HOLD  = 16;
    localparam int ARM   = 4;
    localparam int HALF  = 8;
    localparam int NFR   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk = 1'b0;
    logic sdin = 1'b0;
    logic [TAG_W-1:0]      tx_tag = '0;
    logic [DATA_VEC_W-1:0] tx_slot = '0;
    logic sync_w, sdout_w, codec_n_w, done_w;
    logic [TAG_W-1:0]      rx_tag_w;
    logic [DATA_VEC_W-1:0] rx_slot_w;

    int n_cmp = 0;
    int n_bad = 0;
    int n_done = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    alink_frame_ctrl #(.RST_HOLD(HOLD), .ARM_EDGES(ARM), .SYNC_STAGES(2)) i_alink_frame_ctrl (
        .clk           (clk),
        .rst           (rst),
        .bclk_i        (bclk),
        .sdin_i        (sdin),
        .tx_tag_i      (tx_tag),
        .tx_slot_i     (tx_slot),
        .sync_o        (sync_w),
        .sdout_o       (sdout_w),
        .codec_rst_n_o (codec_n_w),
        .rx_tag_o      (rx_tag_w),
        .rx_slot_o     (rx_slot_w),
        .frame_done_o  (done_w)
    );

    always @(negedge clk) if (!rst && done_w) n_done++;

    function automatic logic [19:0] mix(int f, int s, logic [31:0] seed);
        logic [31:0] h;
        h = (32'(f) + 32'd1) * 32'h9E3779B1 ^ (32'(s) + 32'd7) * seed;
        h = h ^ (h >> 15);
        return h[19:0];
    endfunction

    function automatic logic [19:0] word_of(bit rxside, int f, int s);
        logic [19:0] w;
        w = rxside ? mix(f, s, 32'hC2B2AE35) : mix(f, s, 32'h85EBCA6B);
        if (s == 0) w = w & 20'h0FFFF;
        return w;
    endfunction

    function automatic logic frame_bit(bit rxside, int f, int p);
        int s, b, w;
        logic [19:0] wd;
        if (p < 16) begin s = 0; b = p; w = 16; end
        else begin s = 1 + (p - 16) / 20; b = (p - 16) % 20; w = 20; end
        wd = word_of(rxside, f, s);
        return wd[w-1-b];
    endfunction

    function automatic logic [DATA_VEC_W-1:0] slots_of(bit rxside, int f);
        logic [DATA_VEC_W-1:0] v;
        for (int k = 1; k < SLOTS; k++) v[(k-1)*DATA_W +: DATA_W] = word_of(rxside, f, k);
        return v;
    endfunction

    task automatic set_tx(int f);
        logic [19:0] t;
        t = word_of(0, f, 0);
        tx_tag  = t[15:0];
        tx_slot = slots_of(0, f);
    endtask

    task automatic chk(string req, string what, logic [DATA_VEC_W-1:0] act, logic [DATA_VEC_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        set_tx(0);
        repeat (5) @(negedge clk);
        chk("R1", "codec reset during rst", 240'(codec_n_w), 240'(0));
        chk("R2", "line quiet during rst", 240'({sync_w, sdout_w, done_w}), 240'(0));

        @(negedge clk) rst = 1'b0;
        repeat (HOLD - 1) @(negedge clk);
        chk("R1", "codec reset still held", 240'(codec_n_w), 240'(0));
        @(negedge clk);
        chk("R1", "codec reset released", 240'(codec_n_w), 240'(1));

        repeat (40) @(negedge clk);
        chk("R2", "no frame without bit clock", 240'({sync_w, sdout_w}), 240'(0));
        chk("R2", "no strobe without bit clock", 240'(n_done), 240'(0));

        for (int i = 0; i < ARM + NFR * 256 + 50; i++) begin
            int p, f, exp_done;
            p = (i >= ARM) ? (i - ARM) % 256 : -1;
            f = (i >= ARM) ? (i - ARM) / 256 : 0;
            @(negedge clk);
            bclk = 1'b1;
            sdin = (p >= 0) ? frame_bit(1, f, p) : 1'b0;
            repeat (HALF - 1) @(negedge clk);
            chk((i == ARM) ? "R3" : "R4", "frame marker", 240'(sync_w),
                240'((p >= 0) && (p < 16)));
            chk((p > 100) ? "R8" : "R5", "playback bit", 240'(sdout_w),
                240'((p >= 0) ? frame_bit(0, f, p) : 1'b0));
            if (p == 0 && f >= 1) begin
                logic [19:0] tg;
                tg = word_of(1, f - 1, 0);
                chk("R6", "capture tag", 240'(rx_tag_w), 240'(tg[15:0]));
                chk("R6", "capture slots", rx_slot_w, slots_of(1, f - 1));
            end
            if (p == 128 && f >= 1) begin
                chk("R7", "capture held mid-frame", rx_slot_w, slots_of(1, f - 1));
            end
            if (p == 100) set_tx(f + 1);
            @(negedge clk);
            bclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
            exp_done = (i >= ARM) ? (i - ARM + 1) / 256 : 0;
            chk("R7", "frame strobes", 240'(n_done), 240'(exp_done));
        end

        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "codec reset on late rst", 240'(codec_n_w), 240'(0));
        chk("R2", "line quiet on late rst", 240'({sync_w, sdout_w, done_w}), 240'(0));

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule